// File: doc/BRIEF.md
# Converter Readback Frame Controller

This block is a serial master for an external analog-to-digital converter. On a start pulse it lowers chip select, generates a serial clock derived from the system clock, and shifts out a 16-bit command word, most significant bit first. It then keeps clocking to capture the converter's extended output word. That word holds a 16-bit conversion result, a 4-bit channel tag, a 2-bit device tag and a 3-bit range code. Together these are 25 bits, which is not a whole number of bytes.

A length-select input, sampled at start, picks a frame of 40 or 48 serial clocks, so the host always moves whole bytes. A 40-clock frame drops the last range bit. A 48-clock frame adds seven padding positions, and the converter must hold these at zero. When the frame ends, the block raises chip select, which discards any leftover converter bit. It then splits the captured word into fields. It compares the channel tag and the range code with expected values given at start, and it reports the fields and the check flags together with a one-cycle strobe. This gives continuous checking on every conversion.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is high and right after it, `spi_cs_n` is 1 and `spi_sclk`, `spi_mosi` and `done` are 0.
- R2: A frame holds `spi_cs_n` low for N serial clock periods, where N is 40 when `len_long`=0 at start and 48 when it is 1. Each period is HALF_DIV system cycles low followed by HALF_DIV cycles high. Chip select falls at the edge that accepts start and rises at the final falling serial clock edge.
- R3: `spi_mosi` carries `cmd`, bit 15 first. It changes only on falling serial clock edges, or at the frame start, and it is 0 for every period after the 16th.
- R4: `spi_miso` is sampled on each rising serial clock edge. Read period j (period 16+j) feeds field bits MSB-first in this order: j=0..15 `result[15:0]`, j=16..19 `chan[3:0]`, j=20..21 `dev[1:0]`, j=22..24 `rng[2:0]`.
- R5: In a 40-clock frame, `rng[2:1]` holds the two received range bits and `rng[0]` is 0. `rng_mismatch` compares only bits [2:1] with the expected range, and `frame_err` is 0.
- R6: In a 48-clock frame, `frame_err` is 1 when any of the seven trailing periods (j=25..31) delivered a 1 on `spi_miso`.
- R7: `done` is high for exactly one cycle, one system cycle after chip select rises. The field and flag outputs change only at that point and hold until the next frame.
- R8: `chan_mismatch` is 1 exactly when `chan` differs from the expected channel. In a 48-clock frame, `rng_mismatch` is 1 exactly when `rng` differs from the expected range.
- R9: Chip select stays high for more than 2*HALF_DIV system cycles between frames. A start during a frame or during that gap is ignored.
- R10: `cmd`, `len_long`, `exp_chan` and `exp_rng` are latched at the accepted start. Changing them later has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a frame (taken only when idle) |
| len_long | input | 1 | 0: 40-clock frame, 1: 48-clock frame |
| cmd | input | 16 | Command word to send |
| exp_chan | input | 4 | Expected channel tag |
| exp_rng | input | 3 | Expected range code |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to converter |
| spi_miso | input | 1 | Serial data from converter |
| done | output | 1 | One-cycle frame-complete strobe |
| result | output | 16 | Conversion result |
| chan | output | 4 | Received channel tag |
| dev | output | 2 | Received device tag |
| rng | output | 3 | Received range code |
| chan_mismatch | output | 1 | Channel tag differs from expected |
| rng_mismatch | output | 1 | Range code differs from expected |
| frame_err | output | 1 | Nonzero padding in a 48-clock frame |

## Verification
The bench builds the block with HALF_DIV=3. With an odd divider, the first half period, the final falling edge and the two-tick gap each fall on cycle counts that an off-by-one in the tick counter would shift, and the per-cycle comparison of chip select, clock and data line would catch that shift. At this setting a 48-clock frame is short enough that both lengths, range codes differing only in the dropped bit, nonzero padding, starts issued during the frame and during the gap, and a start held high across frames can all be run with many frames to spare.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;
  parameter int CMD_W = 16;
  parameter int RES_W = 16;
  parameter int CH_W  = 4;
  parameter int DEV_W = 2;
  parameter int RNG_W = 3;
  parameter int CAP_W = 32;
  parameter int TRIM  = 8;
  localparam int PAD_W      = CAP_W - RES_W - CH_W - DEV_W - RNG_W;
  localparam int LONG_CLKS  = CMD_W + CAP_W;
  localparam int SHORT_CLKS = LONG_CLKS - TRIM;
  localparam int IDX_W      = $clog2(LONG_CLKS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} seq_state_t;

  typedef struct packed {
    logic [RES_W-1:0] result;
    logic [CH_W-1:0]  chan;
    logic [DEV_W-1:0] dev;
    logic [RNG_W-1:0] rng;
  } fields_t;
endpackage

// File: rtl/adc_rb_tick.sv
module adc_rb_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/adc_rb_engine.sv
module adc_rb_engine
  import adc_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic             len_long,
  input  logic [CMD_W-1:0] cmd,
  input  logic             miso,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  output logic             active,
  output logic             accept,
  output logic             frame_end,
  output logic             cap_long,
  output logic [CAP_W-1:0] cap
);
  seq_state_t       state;
  logic [IDX_W-1:0] bit_idx;
  logic [IDX_W-1:0] last_idx;
  logic [CMD_W-1:0] cmd_sh;
  logic             len_q;
  logic             gap_t;

  assign last_idx = len_q ? IDX_W'(LONG_CLKS - 1) : IDX_W'(SHORT_CLKS - 1);
  assign accept   = (state == ST_IDLE) && start;
  assign active   = (state != ST_IDLE);
  assign cap_long = len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      bit_idx   <= '0;
      cmd_sh    <= '0;
      cap       <= '0;
      len_q     <= 1'b0;
      gap_t     <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            cs_n    <= 1'b0;
            sclk    <= 1'b0;
            mosi    <= cmd[CMD_W-1];
            cmd_sh  <= {cmd[CMD_W-2:0], 1'b0};
            bit_idx <= '0;
            len_q   <= len_long;
            gap_t   <= 1'b0;
          end
        end
        ST_RUN: begin
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
              cap  <= {cap[CAP_W-2:0], miso};
            end else begin
              sclk <= 1'b0;
              if (bit_idx == last_idx) begin
                cs_n      <= 1'b1;
                state     <= ST_GAP;
                frame_end <= 1'b1;
              end else begin
                bit_idx <= bit_idx + 1'b1;
                mosi    <= cmd_sh[CMD_W-1];
                cmd_sh  <= {cmd_sh[CMD_W-2:0], 1'b0};
              end
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_t) state <= ST_IDLE;
            else       gap_t <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rb_fields.sv
module adc_rb_fields
  import adc_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [CH_W-1:0]  exp_chan,
  input  logic [RNG_W-1:0] exp_rng,
  input  logic             frame_end,
  input  logic             cap_long,
  input  logic [CAP_W-1:0] cap,
  output logic             done,
  output fields_t          fld,
  output logic             chan_mismatch,
  output logic             rng_mismatch,
  output logic             frame_err
);
  logic [CH_W-1:0]  xch_q;
  logic [RNG_W-1:0] xrng_q;
  logic [CAP_W-1:0] norm;
  fields_t          nf;
  logic [PAD_W-1:0] pad;

  assign norm = cap_long ? cap : {cap[CAP_W-TRIM-1:0], {TRIM{1'b0}}};
  assign nf   = fields_t'(norm[CAP_W-1 -: $bits(fields_t)]);
  assign pad  = norm[PAD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      xch_q         <= '0;
      xrng_q        <= '0;
      done          <= 1'b0;
      fld           <= '0;
      chan_mismatch <= 1'b0;
      rng_mismatch  <= 1'b0;
      frame_err     <= 1'b0;
    end else begin
      done <= frame_end;
      if (accept) begin
        xch_q  <= exp_chan;
        xrng_q <= exp_rng;
      end
      if (frame_end) begin
        fld           <= nf;
        chan_mismatch <= (nf.chan != xch_q);
        rng_mismatch  <= cap_long ? (nf.rng != xrng_q)
                                  : (nf.rng[RNG_W-1:1] != xrng_q[RNG_W-1:1]);
        frame_err     <= cap_long && (|pad);
      end
    end
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rb_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             len_long,
  input  logic [CMD_W-1:0] cmd,
  input  logic [CH_W-1:0]  exp_chan,
  input  logic [RNG_W-1:0] exp_rng,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic [CH_W-1:0]  chan,
  output logic [DEV_W-1:0] dev,
  output logic [RNG_W-1:0] rng,
  output logic             chan_mismatch,
  output logic             rng_mismatch,
  output logic             frame_err
);
  logic             tick, active, accept, frame_end, cap_long;
  logic [CAP_W-1:0] cap;
  fields_t          fld;

  adc_rb_tick #(.HALF_DIV(HALF_DIV)) tick_i (
    .clk(clk), .rst(rst), .en(active), .tick(tick)
  );

  adc_rb_engine eng_i (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .len_long(len_long),
    .cmd(cmd), .miso(spi_miso), .cs_n(spi_cs_n), .sclk(spi_sclk),
    .mosi(spi_mosi), .active(active), .accept(accept),
    .frame_end(frame_end), .cap_long(cap_long), .cap(cap)
  );

  adc_rb_fields fld_i (
    .clk(clk), .rst(rst), .accept(accept), .exp_chan(exp_chan),
    .exp_rng(exp_rng), .frame_end(frame_end), .cap_long(cap_long),
    .cap(cap), .done(done), .fld(fld), .chan_mismatch(chan_mismatch),
    .rng_mismatch(rng_mismatch), .frame_err(frame_err)
  );

  assign result = fld.result;
  assign chan   = fld.chan;
  assign dev    = fld.dev;
  assign rng    = fld.rng;
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic done
);
  localparam int GAP_MIN = 2 * HALF_DIV;
  localparam int GW = $clog2(GAP_MIN + 2);

  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst)                             gap_cnt <= GW'(GAP_MIN);
    else if (!spi_cs_n)                  gap_cnt <= '0;
    else if (gap_cnt < GW'(GAP_MIN + 1)) gap_cnt <= gap_cnt + 1'b1;
  end

  // R2
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  // R3
  mosi_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && spi_sclk) |-> $stable(spi_mosi));

  // R7
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_follows_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |=> done);

  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> (gap_cnt > GW'(GAP_MIN)));
endmodule

bind adc_frame_reader adc_frame_reader_chk #(.HALF_DIV(HALF_DIV)) chk_i (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi), .done(done)
);

// File: tb/adc_frame_reader_tb.sv
`timescale 1ns/1ps
module adc_frame_reader_tb_top;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        len_long = 1'b0;
  logic [15:0] cmd = '0;
  logic [3:0]  exp_chan = '0;
  logic [2:0]  exp_rng = '0;
  logic        spi_cs_n, spi_sclk, spi_mosi, spi_miso;
  logic        done, chan_mismatch, rng_mismatch, frame_err;
  logic [15:0] result;
  logic [3:0]  chan;
  logic [1:0]  dev;
  logic [2:0]  rng;

  always #2.5 clk = ~clk;

  adc_frame_reader #(.HALF_DIV(H)) dut_i (
    .clk(clk), .rst(rst), .start(start), .len_long(len_long), .cmd(cmd),
    .exp_chan(exp_chan), .exp_rng(exp_rng), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .done(done), .result(result), .chan(chan), .dev(dev), .rng(rng),
    .chan_mismatch(chan_mismatch), .rng_mismatch(rng_mismatch),
    .frame_err(frame_err)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string phase_tag = "R2";

  // converter model: 25-bit word then 7 padding bits, changes on falling sclk
  logic [24:0] drv_word = '0;
  logic [6:0]  drv_pad  = '0;
  int          fcount   = 0;

  always @(negedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) fcount = 0;
    else          fcount = fcount + 1;
  end

  always_comb begin
    if (spi_cs_n || fcount < 16) spi_miso = 1'b1;
    else if (fcount < 41)        spi_miso = drv_word[24 - (fcount - 16)];
    else if (fcount < 48)        spi_miso = drv_pad[6 - (fcount - 41)];
    else                         spi_miso = 1'b0;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, expv, cycles);
    end
  endtask

  // reference model, advanced on every rising edge
  bit          m_started = 0, m_idle = 1;
  int          m_e = 0, m_n = 40;
  logic [15:0] m_cmd;
  bit          m_long;
  logic [3:0]  m_xch;
  logic [2:0]  m_xr;
  logic [24:0] m_word;
  logic [6:0]  m_pad;
  bit          have_f = 0;
  logic [15:0] f_res;
  logic [3:0]  f_ch;
  logic [1:0]  f_dev;
  logic [2:0]  f_rng;
  bit          f_cm, f_rm, f_fe;

  always @(posedge clk) begin
    if (rst) begin
      m_started = 0; m_idle = 1; m_e = 0; have_f = 0;
    end else if (m_idle) begin
      if (start) begin
        m_started = 1; m_idle = 0; m_e = 0;
        m_cmd = cmd; m_long = len_long; m_n = len_long ? 48 : 40;
        m_xch = exp_chan; m_xr = exp_rng; m_word = drv_word; m_pad = drv_pad;
      end
    end else begin
      m_e++;
      if (m_e == 2 * m_n * H + 1) begin
        have_f = 1;
        f_res = m_word[24:9];
        f_ch  = m_word[8:5];
        f_dev = m_word[4:3];
        f_rng = m_long ? m_word[2:0] : {m_word[2:1], 1'b0};
        f_cm  = (f_ch != m_xch);
        f_rm  = m_long ? (f_rng != m_xr) : (f_rng[2:1] != m_xr[2:1]);
        f_fe  = m_long && (m_pad != 0);
      end
      if (m_e == (2 * m_n + 2) * H) m_idle = 1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      bit in_f;
      bit e_cs, e_sclk, e_mosi, e_done;
      int per;
      in_f   = m_started && (m_e < 2 * m_n * H);
      per    = m_e / (2 * H);
      e_cs   = !in_f;
      e_sclk = in_f && (((m_e / H) % 2) == 1);
      e_mosi = in_f && (per < 16) && m_cmd[15 - per];
      e_done = m_started && !m_idle && (m_e == 2 * m_n * H + 1);
      chk((phase_tag == "R2") ? "R9 cs_n" : {phase_tag, " cs_n"}, spi_cs_n, e_cs);
      chk((phase_tag == "R2") ? "R2 sclk" : {phase_tag, " sclk"}, spi_sclk, e_sclk);
      chk("R3 mosi", spi_mosi, e_mosi);
      chk("R7 done", done, e_done);
      if (have_f) begin
        chk("R4 result", result, f_res);
        chk("R4 chan", chan, f_ch);
        chk("R4 dev", dev, f_dev);
        chk(m_long ? "R4 rng" : "R5 rng", rng, f_rng);
        chk("R8 chan_mismatch", chan_mismatch, f_cm);
        chk(m_long ? "R8 rng_mismatch" : "R5 rng_mismatch", rng_mismatch, f_rm);
        chk(m_long ? "R6 frame_err" : "R5 frame_err", frame_err, f_fe);
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!m_idle) @(negedge clk);
  endtask

  task automatic run_frame(input logic [15:0] c, input bit lng,
                           input logic [24:0] w, input logic [6:0] p,
                           input logic [3:0] xc, input logic [2:0] xr,
                           input bit disturb);
    @(negedge clk);
    drv_word = w; drv_pad = p;
    cmd = c; len_long = lng; exp_chan = xc; exp_rng = xr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R10: changed inputs and a stray start mid-frame must not matter
      phase_tag = "R10";
      repeat (20) @(negedge clk);
      cmd = ~c; len_long = ~lng; exp_chan = ~xc; exp_rng = ~xr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (spi_cs_n == 1'b0) @(negedge clk);
      // R9: start during the gap is ignored
      phase_tag = "R9";
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_idle();
    phase_tag = "R2";
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", spi_cs_n, 1'b1);
    chk("R1 sclk", spi_sclk, 1'b0);
    chk("R1 mosi", spi_mosi, 1'b0);
    chk("R1 done", done, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // word = {result16, chan4, dev2, rng3}
    run_frame(16'hA5C3, 1'b0, {16'h8001, 4'h6, 2'b10, 3'b110}, 7'h00, 4'h6, 3'b110, 0);
    run_frame(16'h1234, 1'b1, {16'h7FFE, 4'h9, 2'b01, 3'b011}, 7'h00, 4'h9, 3'b011, 0);
    run_frame(16'hFFFF, 1'b1, {16'h0F0F, 4'h3, 2'b11, 3'b101}, 7'h41, 4'h4, 3'b101, 0);
    run_frame(16'h0001, 1'b1, {16'hC3C3, 4'hA, 2'b00, 3'b100}, 7'h01, 4'hA, 3'b101, 0);
    // R5: only the dropped range bit differs -> no mismatch
    run_frame(16'h8000, 1'b0, {16'h1357, 4'hF, 2'b01, 3'b100}, 7'h7F, 4'hF, 3'b101, 0);
    run_frame(16'h5A5A, 1'b0, {16'h2468, 4'h0, 2'b10, 3'b010}, 7'h00, 4'h1, 3'b100, 0);
    run_frame(16'hBEEF, 1'b1, {16'hDEAD, 4'h5, 2'b11, 3'b111}, 7'h00, 4'h5, 3'b111, 1);
    run_frame(16'h0F0F, 1'b0, {16'h4321, 4'hC, 2'b00, 3'b001}, 7'h10, 4'hC, 3'b000, 1);
    // R9: start held high across frames -> earliest restart only
    @(negedge clk);
    drv_word = {16'h6666, 4'h2, 2'b01, 3'b010}; drv_pad = 7'h00;
    cmd = 16'hC001; len_long = 1'b0; exp_chan = 4'h2; exp_rng = 3'b010;
    phase_tag = "R9";
    start = 1'b1;
    repeat ((2 * 40 + 2) * H * 2 + 10) @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule